// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block merges every system reset request into a single stretched reset output and keeps a record of which request caused the most recent reset. The request sources are a power-on event, a supply-monitor trip, an external reset pin, a missing-clock timeout, a flash access error, a USB bus reset and a software request. The analog monitor, the clock-loss timer and the USB and flash engines sit outside the block. Each of them reaches it only as a pulse on an input. The power-on input also serves as the block's own synchronous reset.

Software reaches the block through one 8-bit special-function register at address 0xEF. A read of this register returns the captured cause. A write to the same register uses the same bit positions for something else. It turns the optional sources on or off, and it can force a software reset. The source enables live in hidden registers that a read never shows.

Top module: `reset_cause_ctrl`

## Requirements
- R1: A read with the address at 0xEF returns the cause byte, and bits 5 and 3 of that byte always read 0. Writes to bits 5 and 3 have no effect. A read at any other address returns 0x00.
- R2: When power-on is sampled high, the cause byte becomes 0x02 (bit 1 only). The enables return to their defaults: supply monitor on, missing-clock off, USB off. Any lower-priority source active in the same cycle is not recorded.
- R3: A write with bit 4 set forces a reset, and the cause byte then reads 0x10. A write with bit 4 clear forces no reset.
- R4: Write bit 7 enables (1) or disables (0) the USB bus reset. An enabled USB pulse resets the system and records 0x80. A disabled USB pulse leaves the output and the cause byte unchanged.
- R5: Write bit 2 enables or disables the missing-clock source. An enabled timeout resets the system and records 0x04. A disabled timeout is ignored.
- R6: Write bit 1 selects or deselects the supply monitor. A selected trip resets the system and records 0x02. A deselected trip is ignored.
- R7: The reset pin and a flash error always cause a reset and record 0x01 and 0x40. A write cannot set or clear these flags.
- R8: A reset event clears every cause flag except the one for the winning source. The priority order from highest to lowest is power-on, supply monitor, pin, missing clock, flash, USB, software.
- R9: The reset output goes high in the cycle after a source is sampled. It stays high for STRETCH_CYCLES cycles (default 16) after the last cycle in which a source was sampled active.
- R10: A register write that arrives while the reset output is high, or in a cycle with an active hardware source, is ignored. It changes no enable and forces no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_on_i | input | 1 | Power-on event; also the block's synchronous reset |
| supmon_trip_i | input | 1 | Supply monitor trip pulse |
| pin_rst_i | input | 1 | External reset pin, synchronised |
| clk_loss_i | input | 1 | Missing-clock timeout pulse |
| flash_err_i | input | 1 | Flash access error pulse |
| usb_bus_rst_i | input | 1 | USB bus reset pulse |
| sfr_addr_i | input | ADDR_W | Register address |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data (cause byte or zero) |
| sys_rst_o | output | 1 | Stretched system reset |

## Verification
The bench drives several sources together. A design with the wrong priority order would record a lower-priority cause, or more than one cause. After each enable is turned off, the bench pulses that source. A design that ignores the enable would reset and overwrite the recorded cause. The bench writes the register while the reset output is high. A design that accepts such writes would start a second software reset or change an enable in a way that shows up later. The bench also counts the exact stretch length after both single-cycle and held sources, which catches counters that are off by one cycle.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int SFR_W     = 8;
    localparam int BIT_USB   = 7;
    localparam int BIT_FLASH = 6;
    localparam int BIT_SW    = 4;
    localparam int BIT_CLK   = 2;
    localparam int BIT_PWR   = 1;
    localparam int BIT_PIN   = 0;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_PWR,
        CAUSE_SUPMON,
        CAUSE_PIN,
        CAUSE_CLK,
        CAUSE_FLASH,
        CAUSE_USB,
        CAUSE_SW
    } cause_e;

    // Captured cause flags (readable view)
    typedef struct packed {
        logic usb;
        logic flash;
        logic sw;
        logic clk;
        logic pwr;
        logic pin;
    } flags_t;

    // Hidden source enables (write-only view)
    typedef struct packed {
        logic usb;
        logic clk;
        logic supmon;
    } enables_t;

    // Raw request vector
    typedef struct packed {
        logic pwr;
        logic supmon;
        logic pin;
        logic clk;
        logic flash;
        logic usb;
    } src_t;

    localparam enables_t EN_DEFAULT = '{usb: 1'b0, clk: 1'b0, supmon: 1'b1};

    function automatic flags_t cause_to_flags(input cause_e c);
        flags_t f;
        f = '0;
        case (c)
            CAUSE_PWR,
            CAUSE_SUPMON: f.pwr   = 1'b1;
            CAUSE_PIN:    f.pin   = 1'b1;
            CAUSE_CLK:    f.clk   = 1'b1;
            CAUSE_FLASH:  f.flash = 1'b1;
            CAUSE_USB:    f.usb   = 1'b1;
            CAUSE_SW:     f.sw    = 1'b1;
            default:      f       = '0;
        endcase
        return f;
    endfunction

    function automatic logic [SFR_W-1:0] flags_to_byte(input flags_t f);
        logic [SFR_W-1:0] b;
        b            = '0;
        b[BIT_USB]   = f.usb;
        b[BIT_FLASH] = f.flash;
        b[BIT_SW]    = f.sw;
        b[BIT_CLK]   = f.clk;
        b[BIT_PWR]   = f.pwr;
        b[BIT_PIN]   = f.pin;
        return b;
    endfunction

    function automatic enables_t byte_to_enables(input logic [SFR_W-1:0] d);
        enables_t e;
        e.usb    = d[BIT_USB];
        e.clk    = d[BIT_CLK];
        e.supmon = d[BIT_PWR];
        return e;
    endfunction

    // Fixed priority: power-on first, software last
    function automatic cause_e pick_cause(input src_t s, input logic sw);
        cause_e c;
        if (s.pwr)         c = CAUSE_PWR;
        else if (s.supmon) c = CAUSE_SUPMON;
        else if (s.pin)    c = CAUSE_PIN;
        else if (s.clk)    c = CAUSE_CLK;
        else if (s.flash)  c = CAUSE_FLASH;
        else if (s.usb)    c = CAUSE_USB;
        else if (sw)       c = CAUSE_SW;
        else               c = CAUSE_NONE;
        return c;
    endfunction

endpackage

// File: rtl/rcc_src_arb.sv
module rcc_src_arb
    import rcc_pkg::*;
(
    input  src_t     raw_i,
    input  enables_t en_i,
    input  logic     sw_req_i,
    output logic     hw_any_o,
    output logic     any_o,
    output cause_e   cause_o
);
    src_t gated;

    always_comb begin
        gated        = raw_i;
        gated.supmon = raw_i.supmon & en_i.supmon;
        gated.clk    = raw_i.clk    & en_i.clk;
        gated.usb    = raw_i.usb    & en_i.usb;
    end

    assign hw_any_o = |gated;
    assign any_o    = hw_any_o | sw_req_i;
    assign cause_o  = pick_cause(gated, sw_req_i);

endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
    import rcc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SFR_ADDR = 8'hEF
) (
    input  logic              clk,
    input  logic              pwr_on_i,
    input  logic              any_i,
    input  cause_e            cause_i,
    input  logic              wr_ok_i,
    input  logic [SFR_W-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SFR_W-1:0]  rdata_o,
    output enables_t          en_o
);
    flags_t   flags_q;
    enables_t en_q;

    always_ff @(posedge clk) begin
        if (pwr_on_i) begin
            flags_q <= cause_to_flags(CAUSE_PWR);
            en_q    <= EN_DEFAULT;
        end else begin
            if (any_i) begin
                flags_q <= cause_to_flags(cause_i);
            end
            if (wr_ok_i) begin
                en_q <= byte_to_enables(wdata_i);
            end
        end
    end

    assign en_o    = en_q;
    assign rdata_o = (addr_i == SFR_ADDR) ? flags_to_byte(flags_q) : '0;

endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
    parameter int STRETCH_CYCLES = 16
) (
    input  logic clk,
    input  logic trig_i,
    output logic rst_o
);
    generate
        if (STRETCH_CYCLES == 0) begin : g_direct
            logic hold_q;
            always_ff @(posedge clk) hold_q <= trig_i;
            assign rst_o = hold_q;
        end else begin : g_count
            localparam int CW = $clog2(STRETCH_CYCLES + 1);
            localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYCLES);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (trig_i)
                    cnt_q <= LOAD;
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - CW'(1);
            end
            assign rst_o = (cnt_q != '0);
        end
    endgenerate

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] SFR_ADDR       = 8'hEF,
    parameter int                STRETCH_CYCLES = 16
) (
    input  logic              clk,
    input  logic              pwr_on_i,
    input  logic              supmon_trip_i,
    input  logic              pin_rst_i,
    input  logic              clk_loss_i,
    input  logic              flash_err_i,
    input  logic              usb_bus_rst_i,
    input  logic [ADDR_W-1:0] sfr_addr_i,
    input  logic              sfr_wr_i,
    input  logic [7:0]        sfr_wdata_i,
    output logic [7:0]        sfr_rdata_o,
    output logic              sys_rst_o
);
    src_t     raw;
    enables_t en;
    cause_e   cause;
    logic     hw_any, any, wr_hit, wr_ok, sw_req;

    assign raw = '{pwr: pwr_on_i, supmon: supmon_trip_i, pin: pin_rst_i,
                   clk: clk_loss_i, flash: flash_err_i, usb: usb_bus_rst_i};

    // Writes land only while the system runs and no hardware source is active
    assign wr_hit = sfr_wr_i & (sfr_addr_i == SFR_ADDR);
    assign wr_ok  = wr_hit & ~sys_rst_o & ~hw_any;
    assign sw_req = wr_ok & sfr_wdata_i[BIT_SW];

    rcc_src_arb u_arb (
        .raw_i    (raw),
        .en_i     (en),
        .sw_req_i (sw_req),
        .hw_any_o (hw_any),
        .any_o    (any),
        .cause_o  (cause)
    );

    rcc_cause_reg #(
        .ADDR_W   (ADDR_W),
        .SFR_ADDR (SFR_ADDR)
    ) u_regs (
        .clk      (clk),
        .pwr_on_i (pwr_on_i),
        .any_i    (any),
        .cause_i  (cause),
        .wr_ok_i  (wr_ok),
        .wdata_i  (sfr_wdata_i),
        .addr_i   (sfr_addr_i),
        .rdata_o  (sfr_rdata_o),
        .en_o     (en)
    );

    rcc_stretch #(
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_stretch (
        .clk    (clk),
        .trig_i (any),
        .rst_o  (sys_rst_o)
    );

endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk #(
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] SFR_ADDR       = 8'hEF,
    parameter int                STRETCH_CYCLES = 16
) (
    input logic              clk,
    input logic              pwr_on_i,
    input logic              pin_rst_i,
    input logic              flash_err_i,
    input logic [ADDR_W-1:0] sfr_addr_i,
    input logic              sfr_wr_i,
    input logic [7:0]        sfr_wdata_i,
    input logic [7:0]        sfr_rdata_o,
    input logic              sys_rst_o
);
    localparam int CW = $clog2(STRETCH_CYCLES + 2);
    logic [CW-1:0] hold_q;

    // Minimum high window owed after an always-on source
    always_ff @(posedge clk) begin
        if (pwr_on_i || pin_rst_i || flash_err_i)
            hold_q <= CW'(STRETCH_CYCLES);
        else if (hold_q != '0)
            hold_q <= hold_q - CW'(1);
    end

    // R1
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (pwr_on_i)
        (sfr_rdata_o[5] == 1'b0) && (sfr_rdata_o[3] == 1'b0));

    // R1
    other_addr_zero_chk: assert property (@(posedge clk) disable iff (pwr_on_i)
        (sfr_addr_i != SFR_ADDR) |-> (sfr_rdata_o == 8'h00));

    // R8
    single_cause_chk: assert property (@(posedge clk) disable iff (pwr_on_i)
        $onehot0(sfr_rdata_o));

    // R2
    por_cause_chk: assert property (@(posedge clk) disable iff (pwr_on_i)
        ($fell(pwr_on_i) && (sfr_addr_i == SFR_ADDR)) |-> (sfr_rdata_o == 8'h02));

    // R3
    sw_force_chk: assert property (@(posedge clk) disable iff (pwr_on_i)
        (sfr_wr_i && (sfr_addr_i == SFR_ADDR) && sfr_wdata_i[4] && !sys_rst_o) |=> sys_rst_o);

    // R7
    hard_src_rst_chk: assert property (@(posedge clk) disable iff (pwr_on_i)
        (pin_rst_i || flash_err_i) |=> sys_rst_o);

    // R9
    stretch_hold_chk: assert property (@(posedge clk) disable iff (pwr_on_i)
        (hold_q != '0) |-> sys_rst_o);

endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk #(
    .ADDR_W         (ADDR_W),
    .SFR_ADDR       (SFR_ADDR),
    .STRETCH_CYCLES (STRETCH_CYCLES)
) u_chk (
    .clk         (clk),
    .pwr_on_i    (pwr_on_i),
    .pin_rst_i   (pin_rst_i),
    .flash_err_i (flash_err_i),
    .sfr_addr_i  (sfr_addr_i),
    .sfr_wr_i    (sfr_wr_i),
    .sfr_wdata_i (sfr_wdata_i),
    .sfr_rdata_o (sfr_rdata_o),
    .sys_rst_o   (sys_rst_o)
);

// File: tb/reset_cause_ctrl_tb.sv
module reset_cause_ctrl_tb;
    localparam int STRETCH = 16;
    localparam logic [7:0] ADDR = 8'hEF;

    // source mask bit order: pwr, supmon, pin, clk, flash, usb
    localparam logic [5:0] M_PWR = 6'b100000, M_SUP = 6'b010000, M_PIN = 6'b001000,
                           M_CLK = 6'b000100, M_FLS = 6'b000010, M_USB = 6'b000001;

    logic clk = 1'b0;
    logic pwr_on = 1'b1, supmon = 1'b0, pin = 1'b0, clkloss = 1'b0, flash = 1'b0, usb = 1'b0;
    logic [7:0] addr = ADDR, wdata = 8'h00, rdata;
    logic wr = 1'b0, rst_o;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    reset_cause_ctrl #(.STRETCH_CYCLES(STRETCH)) u_dut (
        .clk(clk), .pwr_on_i(pwr_on), .supmon_trip_i(supmon), .pin_rst_i(pin),
        .clk_loss_i(clkloss), .flash_err_i(flash), .usb_bus_rst_i(usb),
        .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_wdata_i(wdata),
        .sfr_rdata_o(rdata), .sys_rst_o(rst_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_cause(input string req, input logic [7:0] exp);
        addr = ADDR;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic sfr_write(input logic [7:0] d);
        addr = ADDR; wdata = d; wr = 1'b1;
        step(1);
        wr = 1'b0;
    endtask

    task automatic drive_src(input logic [5:0] m);
        {pwr_on, supmon, pin, clkloss, flash, usb} = m;
    endtask

    task automatic wait_quiet(output int n);
        n = 0;
        while (rst_o && n < 200) begin
            n++;
            step(1);
        end
    endtask

    // pulse for one cycle; expect reset or not, then let it drain
    task automatic pulse(input string req, input logic [5:0] m, input bit expect_rst);
        int n;
        drive_src(m);
        step(1);
        drive_src('0);
        check(req, rst_o, expect_rst);
        wait_quiet(n);
        step(2);
    endtask

    task automatic t_power_on;
        int n;
        drive_src(M_PWR);
        step(1);
        drive_src('0);
        check("R9", rst_o, 1);
        read_cause("R2", 8'h02);
        wait_quiet(n);
        check("R9", n, STRETCH);
        step(2);
    endtask

    task automatic t_defaults;
        t_power_on();
        addr = 8'hEE; #1; check("R1", rdata, 8'h00);
        pulse("R4", M_USB, 0);
        read_cause("R4", 8'h02);
        pulse("R5", M_CLK, 0);
        read_cause("R5", 8'h02);
        pulse("R7", M_PIN, 1);
        read_cause("R7", 8'h01);
        pulse("R6", M_SUP, 1);
        read_cause("R6", 8'h02);
    endtask

    task automatic t_flash_and_unused;
        pulse("R7", M_FLS, 1);
        read_cause("R7", 8'h40);
        sfr_write(8'h41);
        check("R7", rst_o, 0);
        read_cause("R7", 8'h40);
        sfr_write(8'h28);
        check("R1", rst_o, 0);
        read_cause("R1", 8'h40);
    endtask

    task automatic t_software;
        int n;
        sfr_write(8'h00);
        check("R3", rst_o, 0);
        read_cause("R3", 8'h40);
        sfr_write(8'h10);
        check("R3", rst_o, 1);
        wait_quiet(n);
        check("R9", n, STRETCH);
        read_cause("R3", 8'h10);
        step(2);
    endtask

    task automatic t_usb_clk;
        sfr_write(8'h80);
        pulse("R4", M_USB, 1);
        read_cause("R4", 8'h80);
        sfr_write(8'h00);
        pulse("R4", M_USB, 0);
        read_cause("R4", 8'h80);
        sfr_write(8'h04);
        pulse("R5", M_CLK, 1);
        read_cause("R5", 8'h04);
        sfr_write(8'h00);
        pulse("R5", M_CLK, 0);
        read_cause("R5", 8'h04);
        pulse("R6", M_SUP, 0);
        read_cause("R6", 8'h04);
    endtask

    task automatic t_priority;
        sfr_write(8'h86);
        pulse("R8", M_PIN | M_CLK | M_FLS | M_USB, 1);
        read_cause("R8", 8'h01);
        pulse("R8", M_CLK | M_FLS | M_USB, 1);
        read_cause("R8", 8'h04);
        pulse("R8", M_FLS | M_USB, 1);
        read_cause("R8", 8'h40);
        pulse("R8", M_SUP | M_PIN, 1);
        read_cause("R8", 8'h02);
        pulse("R2", M_PWR | M_PIN | M_USB, 1);
        read_cause("R2", 8'h02);
        pulse("R2", M_USB, 0);
        read_cause("R2", 8'h02);
    endtask

    task automatic t_write_in_reset;
        int n;
        drive_src(M_PIN);
        step(1);
        drive_src('0);
        sfr_write(8'h90);
        check("R10", rst_o, 1);
        wait_quiet(n);
        step(3);
        check("R10", rst_o, 0);
        read_cause("R10", 8'h01);
        pulse("R10", M_USB, 0);
        read_cause("R10", 8'h01);
    endtask

    task automatic t_held_source;
        int n;
        drive_src(M_PIN);
        step(1);
        check("R9", rst_o, 1);
        step(4);
        drive_src('0);
        wait_quiet(n);
        check("R9", n, STRETCH);
        step(2);
    endtask

    bit finished = 0;

    initial begin
        step(1);
        t_defaults();
        t_flash_and_unused();
        t_software();
        t_usb_clk();
        t_priority();
        t_write_in_reset();
        t_held_source();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200_000 * 10);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule